// File: doc/BRIEF.md
# Bit-Stuffed Serial Configuration Receiver

This block accepts the configuration stream of a programmable clock synthesizer over a two-wire serial link: a serial clock and a data line. Both wires are resynchronized into the system clock domain, and a data bit is taken on every rising edge of the serial clock. Words travel least significant bit first. The transmitter inserts a zero after every run of three ones, so the receiver discards that zero. A run of four ones can then only be a delimiter.

A delimiter loads an 8-bit control register from the eight data bits that precede it. While the control register's load-enable bit is set, data bits also advance a program shift chain. A later control write that clears the enable bit commits the chain into the 22-bit program register. That register drives the index, Q', post-divider select, duty adjust and P' fields. A one-cycle strobe marks each control update and each program update. A sticky flag reports a run of five ones.

Top module: `cfg_rx`

## Requirements
- R1: A data bit is the value of the data line at a rising edge of the serial clock; changes of the data line while the serial clock stays high have no effect on the received value.
- R2: After reset the control register reads 0x04, all program fields read 0, and both strobes and the error flag are 0.
- R3: After three consecutive received data ones, a following 0 is discarded and is not counted as data, whatever real bit follows it.
- R4: A one that follows three consecutive data ones is a delimiter. The control register then loads the eight data bits received before the delimiter's leading 0 and its three ones, with the earliest of the eight in bit 0. Exactly one ctrl_stb pulse is raised, and the 0 that closes the delimiter is not data.
- R5: Control bit 0 enables program loading. When a delimiter writes a control value with bit 0 = 0 while bit 0 was 1, the program register takes the 22 data bits that came before the final control byte and delimiter, earliest bit in bit 0, and exactly one pgm_stb pulse is raised.
- R6: Program word layout: bits [3:0] index, [10:4] Q', [13:11] post-divider select, [14] duty adjust, [21:15] P'. The program outputs change only on a commit.
- R7: A delimiter that leaves bit 0 at 1, or that writes bit 0 = 0 when it was already 0, does not commit: program outputs and pgm_stb stay unchanged.
- R8: A fifth consecutive one sets frame_err, which stays set until reset. The control value written by the fourth one is kept.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| sclk_i | input | 1 | Serial clock, asynchronous |
| sdata_i | input | 1 | Serial data, asynchronous |
| ctrl_reg | output | 8 | Control register (bit0 program enable, bit1 output float, bit2 reference select, bit3 pin mode, bit5 duty adjust) |
| pgm_p | output | 7 | Committed P' field |
| pgm_d | output | 1 | Committed duty adjust bit |
| pgm_m | output | 3 | Committed post-divider select |
| pgm_q | output | 7 | Committed Q' field |
| pgm_idx | output | 4 | Committed index field |
| ctrl_stb | output | 1 | One-cycle pulse on a control register update |
| pgm_stb | output | 1 | One-cycle pulse on a program register update |
| frame_err | output | 1 | Sticky flag for five consecutive ones |

## Verification
A ones counter that is out of step shows up at the next delimiter. Either the control register takes a byte shifted by one position, or a delimiter is missed and no ctrl_stb appears. This becomes visible three system clocks after the serial clock edge that carries the fourth one. A wrong program chain or a wrong enable stays hidden until the committing control write. It then appears as wrong field values together with the pgm_stb pulse. A commit at the wrong time shows as a pgm_stb count that differs from the number of 1-to-0 enable transitions.

// File: rtl/cfg_rx_pkg.sv
package cfg_rx_pkg;
   localparam int unsigned CTRL_W = 8;
   localparam int unsigned IDX_W  = 4;
   localparam int unsigned QV_W   = 7;
   localparam int unsigned MUX_W  = 3;
   localparam int unsigned DUTY_W = 1;
   localparam int unsigned PV_W   = 7;
   localparam int unsigned PROG_W = IDX_W + QV_W + MUX_W + DUTY_W + PV_W;

   typedef struct packed {
      logic [PV_W-1:0]   pv;
      logic [DUTY_W-1:0] duty;
      logic [MUX_W-1:0]  mux;
      logic [QV_W-1:0]   qv;
      logic [IDX_W-1:0]  idx;
   } prog_fields_t;
endpackage

// File: rtl/cfg_rx_sync.sv
module cfg_rx_sync #(
   parameter int unsigned STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic sclk_a,
   input  logic sdata_a,
   output logic strobe,
   output logic bit_val
);
   logic [STAGES-1:0] sc_q;
   logic [STAGES-1:0] sd_q;
   logic              sc_last;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         sc_q    <= '0;
         sd_q    <= '0;
         sc_last <= 1'b0;
      end else begin
         sc_q    <= {sc_q[STAGES-2:0], sclk_a};
         sd_q    <= {sd_q[STAGES-2:0], sdata_a};
         sc_last <= sc_q[STAGES-1];
      end
   end

   assign strobe  = sc_q[STAGES-1] & ~sc_last;
   assign bit_val = sd_q[STAGES-1];

   a_r1_strobe_single: assert property (@(posedge clk) disable iff (!rst_n)
      strobe |=> !strobe);
endmodule

// File: rtl/cfg_rx_destuff.sv
module cfg_rx_destuff #(
   parameter int unsigned RUN = 3
) (
   input  logic clk,
   input  logic rst_n,
   input  logic strobe,
   input  logic bit_in,
   output logic data_vld,
   output logic data_bit,
   output logic frame_evt,
   output logic frame_err
);
   localparam int unsigned CW = $clog2(RUN + 2);
   localparam logic [CW-1:0] RUN_C  = CW'(RUN);
   localparam logic [CW-1:0] FULL_C = CW'(RUN + 1);

   logic [CW-1:0] ones_q;
   logic [CW-1:0] ones_d;
   logic          drop, over, close;

   always_comb begin
      data_vld  = strobe && (ones_q < RUN_C);
      data_bit  = bit_in;
      drop      = strobe && (ones_q == RUN_C) && !bit_in;
      frame_evt = strobe && (ones_q == RUN_C) && bit_in;
      over      = strobe && (ones_q == FULL_C) && bit_in;
      close     = strobe && (ones_q == FULL_C) && !bit_in;
      ones_d    = ones_q;
      if (data_vld)        ones_d = bit_in ? ones_q + 1'b1 : '0;
      else if (drop)       ones_d = '0;
      else if (frame_evt)  ones_d = FULL_C;
      else if (close)      ones_d = '0;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ones_q    <= '0;
         frame_err <= 1'b0;
      end else begin
         ones_q <= ones_d;
         if (over) frame_err <= 1'b1;
      end
   end

   a_r8_err_sticky: assert property (@(posedge clk) disable iff (!rst_n)
      frame_err |=> frame_err);
   a_r3_drop_not_data: assert property (@(posedge clk) disable iff (!rst_n)
      drop |-> !data_vld && !frame_evt);
endmodule

// File: rtl/cfg_rx_regs.sv
module cfg_rx_regs
   import cfg_rx_pkg::*;
#(
   parameter int unsigned      RUN      = 3,
   parameter int unsigned      EN_BIT   = 0,
   parameter logic [CTRL_W-1:0] CTRL_RST = 8'h04
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              data_vld,
   input  logic              data_bit,
   input  logic              frame_evt,
   output logic [CTRL_W-1:0] ctrl_q,
   output logic [PROG_W-1:0] prog_q,
   output logic              ctrl_upd,
   output logic              prog_upd
);
   localparam int unsigned HW = CTRL_W + 1 + RUN;

   logic [HW-1:0]     hist_q;
   logic [PROG_W-1:0] chain_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         hist_q   <= '0;
         chain_q  <= '0;
         ctrl_q   <= CTRL_RST;
         prog_q   <= '0;
         ctrl_upd <= 1'b0;
         prog_upd <= 1'b0;
      end else begin
         ctrl_upd <= 1'b0;
         prog_upd <= 1'b0;
         if (data_vld) begin
            hist_q <= {data_bit, hist_q[HW-1:1]};
            if (ctrl_q[EN_BIT]) chain_q <= {hist_q[0], chain_q[PROG_W-1:1]};
         end
         if (frame_evt) begin
            ctrl_q   <= hist_q[CTRL_W-1:0];
            ctrl_upd <= 1'b1;
            if (ctrl_q[EN_BIT] && !hist_q[EN_BIT]) begin
               prog_q   <= chain_q;
               prog_upd <= 1'b1;
            end
         end
      end
   end

   a_r4_frame_loads_ctrl: assert property (@(posedge clk) disable iff (!rst_n)
      frame_evt |=> ctrl_upd);
   a_r6_prog_hold: assert property (@(posedge clk) disable iff (!rst_n)
      !prog_upd |-> $stable(prog_q));
   a_r5_commit_on_clear: assert property (@(posedge clk) disable iff (!rst_n)
      prog_upd |-> (!ctrl_q[EN_BIT] && $past(ctrl_q[EN_BIT])));
   a_r7_no_commit_disabled: assert property (@(posedge clk) disable iff (!rst_n)
      (frame_evt && !ctrl_q[EN_BIT]) |=> !prog_upd);
endmodule

// File: rtl/cfg_rx.sv
module cfg_rx
   import cfg_rx_pkg::*;
#(
   parameter int unsigned       SYNC_STAGES = 2,
   parameter int unsigned       STUFF_RUN   = 3,
   parameter int unsigned       PROG_EN_BIT = 0,
   parameter logic [CTRL_W-1:0] CTRL_RST    = 8'h04
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              sclk_i,
   input  logic              sdata_i,
   output logic [CTRL_W-1:0] ctrl_reg,
   output logic [PV_W-1:0]   pgm_p,
   output logic              pgm_d,
   output logic [MUX_W-1:0]  pgm_m,
   output logic [QV_W-1:0]   pgm_q,
   output logic [IDX_W-1:0]  pgm_idx,
   output logic              ctrl_stb,
   output logic              pgm_stb,
   output logic              frame_err
);
   if (SYNC_STAGES < 2) begin : g_bad_sync
      $error("cfg_rx: SYNC_STAGES must be at least 2");
   end
   if (STUFF_RUN < 1) begin : g_bad_run
      $error("cfg_rx: STUFF_RUN must be at least 1");
   end
   if (PROG_EN_BIT >= CTRL_W) begin : g_bad_en
      $error("cfg_rx: PROG_EN_BIT outside the control register");
   end

   logic         strobe, bit_val;
   logic         data_vld, data_bit, frame_evt;
   logic [PROG_W-1:0] prog_word;
   prog_fields_t fields;

   cfg_rx_sync #(.STAGES(SYNC_STAGES)) u_sync (
      .clk(clk), .rst_n(rst_n), .sclk_a(sclk_i), .sdata_a(sdata_i),
      .strobe(strobe), .bit_val(bit_val));

   cfg_rx_destuff #(.RUN(STUFF_RUN)) u_destuff (
      .clk(clk), .rst_n(rst_n), .strobe(strobe), .bit_in(bit_val),
      .data_vld(data_vld), .data_bit(data_bit), .frame_evt(frame_evt),
      .frame_err(frame_err));

   cfg_rx_regs #(.RUN(STUFF_RUN), .EN_BIT(PROG_EN_BIT), .CTRL_RST(CTRL_RST)) u_regs (
      .clk(clk), .rst_n(rst_n), .data_vld(data_vld), .data_bit(data_bit),
      .frame_evt(frame_evt), .ctrl_q(ctrl_reg), .prog_q(prog_word),
      .ctrl_upd(ctrl_stb), .prog_upd(pgm_stb));

   assign fields  = prog_word;
   assign pgm_p   = fields.pv;
   assign pgm_d   = fields.duty[0];
   assign pgm_m   = fields.mux;
   assign pgm_q   = fields.qv;
   assign pgm_idx = fields.idx;
endmodule

// File: tb/cfg_rx_test.sv
`timescale 1ns/1ps
module cfg_rx_test;
   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic sclk_i = 1'b0;
   logic sdata_i = 1'b0;
   logic [7:0] ctrl_reg;
   logic [6:0] pgm_p, pgm_q;
   logic       pgm_d, ctrl_stb, pgm_stb, frame_err;
   logic [2:0] pgm_m;
   logic [3:0] pgm_idx;

   int n_cmp = 0, n_mis = 0, ctrl_cnt = 0, pgm_cnt = 0, run = 0;
   bit done = 0;

   always #2 clk = ~clk;

   cfg_rx uut (
      .clk(clk), .rst_n(rst_n), .sclk_i(sclk_i), .sdata_i(sdata_i),
      .ctrl_reg(ctrl_reg), .pgm_p(pgm_p), .pgm_d(pgm_d), .pgm_m(pgm_m),
      .pgm_q(pgm_q), .pgm_idx(pgm_idx), .ctrl_stb(ctrl_stb),
      .pgm_stb(pgm_stb), .frame_err(frame_err));

   always @(posedge clk) begin
      if (ctrl_stb) ctrl_cnt++;
      if (pgm_stb)  pgm_cnt++;
   end

   task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
      n_cmp++;
      if (act !== exp) begin
         n_mis++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   task automatic raw_bit(bit b, bit glitch);
      @(negedge clk) sdata_i = b;
      repeat (3) @(negedge clk);
      sclk_i = 1'b1;
      repeat (3) @(negedge clk);
      if (glitch) sdata_i = ~b;
      repeat (2) @(negedge clk);
      sclk_i = 1'b0;
      repeat (4) @(negedge clk);
   endtask

   task automatic data_bits(logic [31:0] v, int n, bit glitch);
      for (int i = 0; i < n; i++) begin
         raw_bit(v[i], glitch);
         run = v[i] ? run + 1 : 0;
         if (run == 3) begin
            raw_bit(1'b0, glitch);
            run = 0;
         end
      end
   endtask

   task automatic delim();
      raw_bit(0, 0); raw_bit(1, 0); raw_bit(1, 0);
      raw_bit(1, 0); raw_bit(1, 0); raw_bit(0, 0);
      run = 0;
   endtask

   task automatic write_ctrl(logic [7:0] v, bit glitch);
      data_bits({24'd0, v}, 8, glitch);
      delim();
   endtask

   task automatic t_reset();
      chk("R2 ctrl", ctrl_reg, 8'h04);
      chk("R2 prog", {pgm_p, pgm_d, pgm_m, pgm_q, pgm_idx}, 0);
      chk("R2 flags", {ctrl_stb, pgm_stb, frame_err}, 0);
   endtask

   task automatic t_ctrl_write();
      write_ctrl(8'h25, 0);
      chk("R4 ctrl value", ctrl_reg, 8'h25);
      chk("R4 ctrl_stb count", ctrl_cnt, 1);
      write_ctrl(8'hA1, 1);
      chk("R1 glitch while sclk high", ctrl_reg, 8'hA1);
   endtask

   task automatic t_program();
      logic [21:0] w;
      w = {7'd88, 1'b1, 3'd1, 7'd31, 4'd0};
      data_bits({10'd0, w}, 22, 0);
      chk("R6 no change before commit", {pgm_p, pgm_d, pgm_m, pgm_q, pgm_idx}, 0);
      write_ctrl(8'h24, 0);
      chk("R5 program word", {pgm_p, pgm_d, pgm_m, pgm_q, pgm_idx}, w);
      chk("R5 pgm_stb count", pgm_cnt, 1);
      chk("R6 P field", pgm_p, 88);
      chk("R6 Q field", pgm_q, 31);
      chk("R6 M and D", {pgm_m, pgm_d}, {3'd1, 1'b1});
      chk("R6 index", pgm_idx, 0);
      chk("R4 ctrl after commit", ctrl_reg, 8'h24);
   endtask

   task automatic t_no_commit();
      write_ctrl(8'h04, 0);
      chk("R7 disabled stays", pgm_cnt, 1);
      write_ctrl(8'hE7, 0);
      chk("R3 stuffed ctrl E7", ctrl_reg, 8'hE7);
      write_ctrl(8'h77, 0);
      chk("R3 stuffed ctrl 77", ctrl_reg, 8'h77);
      chk("R7 enable kept no commit", pgm_cnt, 1);
      chk("R7 program unchanged", {pgm_p, pgm_q}, {7'd88, 7'd31});
   endtask

   task automatic t_error();
      chk("R8 flag clear before", frame_err, 0);
      data_bits({24'd0, 8'h77}, 8, 0);
      raw_bit(0, 0); raw_bit(1, 0); raw_bit(1, 0); raw_bit(1, 0);
      raw_bit(1, 0); raw_bit(1, 0); raw_bit(0, 0);
      run = 0;
      chk("R8 flag set", frame_err, 1);
      chk("R8 ctrl kept", ctrl_reg, 8'h77);
      write_ctrl(8'h35, 0);
      chk("R8 flag sticky", frame_err, 1);
      chk("R4 ctrl after error", ctrl_reg, 8'h35);
      chk("R4 total ctrl_stb", ctrl_cnt, 8);
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      if (!done) begin
         n_cmp++; n_mis++;
         $display("FAIL watchdog actual=running expected=finished");
         $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_mis);
         $finish;
      end
   end

   initial begin
      repeat (3) @(negedge clk);
      t_reset();
      rst_n = 1'b1;
      repeat (3) @(negedge clk);
      t_ctrl_write();
      t_program();
      t_no_commit();
      t_error();
      done = 1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_mis);
      $finish;
   end
endmodule